// File: doc/BRIEF.md
# Switch Reset and Init Sequencer

This block brings an external Ethernet switch device out of reset and loads its first configuration. After a start pulse it drives the device's reset line through three timed phases: a high settle, a low hold and a high recovery. Timing comes from a millisecond tick supplied by the surrounding logic. While reset is low, it takes over the serial clock, data and select pins of the device's register port and parks them in their power-up strapping levels. It keeps them there until the recovery phase ends, then gives them back.

Once the pins are released, the block sends two fixed register writes, one after the other, to a shared serial register master through a level request and done handshake. The first write configures the CPU-facing port: crossover detection, default VLAN 15, tag insertion, full duplex, 100 Mb/s, autonegotiation and flow control. The second write switches the device into VLAN mode. A flag then reports completion. A parameter can remove the reset phases for boards whose power-on reset already works; the block then goes straight to the writes.

Top module: `sw_rst_init_seq`

## Requirements
- R1: After an accepted start (with reset phases enabled), `rc_oe_o`=1 and `rc_o`=1 for exactly T_HI_MS+1 tick periods. The phase ends on the tick that follows T_HI_MS whole ticks counted inside it.
- R2: The low phase then drives `rc_o`=0 with `rc_oe_o`=1 for exactly T_LO_MS+1 tick periods.
- R3: For the whole low phase, and at the moment reset rises, the pin overrides are all enabled with clock=1, data=0 and select=0.
- R4: A recovery phase drives `rc_o`=1 for exactly T_REC_MS+1 tick periods with the overrides still held. After it all three override enables drop to 0, and `rc_oe_o`=1 and `rc_o`=1 remain.
- R5: The write requests come in this order: first address 0x09 with data 0xBC1F, then address 0x11 with data 0xFF30. No request is raised while any override is enabled or before the reset phases have finished.
- R6: With RST_EN=0, `rc_oe_o` stays 0 and the first write request appears in the cycle after the start is accepted.
- R7: A request stays high with stable address and data until `wr_done_i`. The next request is raised only after that done, so exactly two done handshakes occur per sequence.
- R8: `done_o` rises after the done of the last write. It stays high until the next start, which clears it and reruns the whole sequence.
- R9: A start pulse that arrives while a sequence is running has no effect on phase lengths or on the writes.
- R10: Out of reset, `rc_oe_o`, all override enables, `wr_req_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle or finished |
| ms_tick_i | input | 1 | One-cycle pulse once per millisecond |
| rc_o | output | 1 | Level for the device reset line |
| rc_oe_o | output | 1 | Output enable of the reset line |
| sclk_ovr_en_o | output | 1 | Take over the serial clock pin |
| sclk_ovr_o | output | 1 | Serial clock level while taken over |
| sdat_ovr_en_o | output | 1 | Take over the serial data pin |
| sdat_ovr_o | output | 1 | Serial data level while taken over |
| csel_ovr_en_o | output | 1 | Take over the select pin |
| csel_ovr_o | output | 1 | Select level while taken over |
| wr_req_o | output | 1 | Write request to the serial master |
| wr_addr_o | output | 8 | Register address of the request |
| wr_data_o | output | 16 | Register value of the request |
| wr_done_i | input | 1 | Master finished the current write |
| done_o | output | 1 | Sequence complete |

## Verification
A phase timer that counts one tick too many or too few shifts a reset edge by a whole millisecond. This appears as a tick count one off in the high, low or recovery window, visible at the first reset edge after the bad phase. A broken state transition shows up on the very next tick or handshake as one of: pins released early, a request raised while reset is still low, the two writes swapped or sent twice, or a start pulse in the middle of a run restarting the waveform. Each such error is visible within one sequence. For that reason the sweep reruns the sequence under every combination of tick spacing and master latency.

// File: rtl/sw_rst_init_pkg.sv
// Shared types and fixed configuration constants for the switch reset/init sequencer.
// Assumes the serial master takes 8-bit addresses and 16-bit values.
package sw_rst_init_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_HI,
        ST_RST_LO,
        ST_RST_REC,
        ST_WRITE,
        ST_FIN
    } seq_state_t;

    localparam int WR_COUNT = 2;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;

    // CPU port: crossover(15), VLAN id 15 (13:10), tagging(4), FD/100/AN/FC (3:0)
    localparam logic [ADDR_W-1:0] CPU_PORT_ADDR = 8'h09;
    localparam logic [DATA_W-1:0] CPU_PORT_VAL  = 16'h8000 | (16'hF << 10) | 16'h0010 | 16'h000F;
    // Mode register: VLAN mode on
    localparam logic [ADDR_W-1:0] MODE_ADDR     = 8'h11;
    localparam logic [DATA_W-1:0] MODE_VAL      = 16'hFF30;

endpackage

// File: rtl/sw_tick_timer.sv
// Phase timer: counts millisecond ticks from a clear and flags the tick on
// which the count equals the limit. Assumes the limit is stable within a phase
// and that clr_i is raised on every phase change.
module sw_tick_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    // Tick counter, cleared at phase entry, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (clr_i)                     cnt_q <= '0;
        else if (tick_i && cnt_q != limit_i) cnt_q <= cnt_q + 1'b1;
    end

    // Expiry on the tick that finds the count at the limit
    assign expire_o = tick_i && (cnt_q == limit_i);

    // R1 R2 R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> cnt_q <= limit_i);

endmodule

// File: rtl/sw_cfg_list.sv
// Fixed list of configuration writes, indexed by write number.
// Assumes index 0 is sent first; any higher index maps to the mode write.
module sw_cfg_list
    import sw_rst_init_pkg::*;
#(
    parameter int IDX_W = 1
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    // Select the address/value pair for the current write
    always_comb begin
        if (idx_i == '0) begin
            addr_o = CPU_PORT_ADDR;
            data_o = CPU_PORT_VAL;
        end else begin
            addr_o = MODE_ADDR;
            data_o = MODE_VAL;
        end
    end

endmodule

// File: rtl/sw_rst_init_seq.sv
// Switch reset and init sequencer: three-phase reset waveform with pin presets,
// followed by two chained register writes over a shared serial master.
// Assumes ms_tick_i is a one-cycle pulse and wr_done_i pulses once per request.
module sw_rst_init_seq
    import sw_rst_init_pkg::*;
#(
    parameter bit RST_EN   = 1'b1,
    parameter int T_HI_MS  = 20,
    parameter int T_LO_MS  = 100,
    parameter int T_REC_MS = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ms_tick_i,
    output logic              rc_o,
    output logic              rc_oe_o,
    output logic              sclk_ovr_en_o,
    output logic              sclk_ovr_o,
    output logic              sdat_ovr_en_o,
    output logic              sdat_ovr_o,
    output logic              csel_ovr_en_o,
    output logic              csel_ovr_o,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic              wr_done_i,
    output logic              done_o
);

    localparam int T_MAX1 = (T_HI_MS > T_LO_MS) ? T_HI_MS : T_LO_MS;
    localparam int T_MAX  = (T_MAX1 > T_REC_MS) ? T_MAX1 : T_REC_MS;
    localparam int CNT_W  = $clog2(T_MAX + 1);
    localparam int IDX_W  = (WR_COUNT > 1) ? $clog2(WR_COUNT) : 1;

    seq_state_t       st_q, st_d;
    logic [IDX_W-1:0] idx_q;
    logic             rc_drv_q;
    logic [CNT_W-1:0] limit;
    logic             expire;
    logic             phase_clr;
    logic             accept;
    logic             pin_hold;

    assign accept = start_i && (st_q == ST_IDLE || st_q == ST_FIN);

    // Next-state selection for the reset phases and the write chain
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE, ST_FIN: if (accept) st_d = RST_EN ? ST_RST_HI : ST_WRITE;
            ST_RST_HI:       if (expire) st_d = ST_RST_LO;
            ST_RST_LO:       if (expire) st_d = ST_RST_REC;
            ST_RST_REC:      if (expire) st_d = ST_WRITE;
            ST_WRITE:        if (wr_done_i && idx_q == IDX_W'(WR_COUNT - 1)) st_d = ST_FIN;
            default:         st_d = ST_IDLE;
        endcase
    end

    // Tick limit of the phase in progress
    always_comb begin
        case (st_q)
            ST_RST_HI:  limit = CNT_W'(T_HI_MS);
            ST_RST_LO:  limit = CNT_W'(T_LO_MS);
            ST_RST_REC: limit = CNT_W'(T_REC_MS);
            default:    limit = '0;
        endcase
    end

    assign phase_clr = (st_d != st_q);

    sw_tick_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (phase_clr),
        .tick_i   (ms_tick_i),
        .limit_i  (limit),
        .expire_o (expire)
    );

    // State, write index and sticky reset-drive flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            idx_q    <= '0;
            rc_drv_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept)                               idx_q <= '0;
            else if (st_q == ST_WRITE && wr_done_i)   idx_q <= idx_q + 1'b1;
            if (st_q == ST_RST_REC && expire)         rc_drv_q <= 1'b1;
        end
    end

    sw_cfg_list #(.IDX_W(IDX_W)) list_i (
        .idx_i  (idx_q),
        .addr_o (wr_addr_o),
        .data_o (wr_data_o)
    );

    // Pin and handshake outputs decoded from the state
    always_comb begin
        pin_hold      = (st_q == ST_RST_LO) || (st_q == ST_RST_REC);
        rc_o          = (st_q != ST_RST_LO);
        rc_oe_o       = rc_drv_q || (st_q == ST_RST_HI) || pin_hold;
        sclk_ovr_en_o = pin_hold;
        sclk_ovr_o    = pin_hold;
        sdat_ovr_en_o = pin_hold;
        sdat_ovr_o    = 1'b0;
        csel_ovr_en_o = pin_hold;
        csel_ovr_o    = 1'b0;
        wr_req_o      = (st_q == ST_WRITE);
        done_o        = (st_q == ST_FIN);
    end

    // R3
    preset_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rc_o) |-> sclk_ovr_en_o && sclk_ovr_o && sdat_ovr_en_o && !sdat_ovr_o);

    // R5
    write_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> !sclk_ovr_en_o && !csel_ovr_en_o && (rc_oe_o == RST_EN));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_done_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o);

    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> $past(start_i));

endmodule

// File: tb/sw_rst_init_seq_tb.sv
module sw_rst_init_seq_tb_top;

    localparam int THI  = 20;
    localparam int TLO  = 100;
    localparam int TREC = 30;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic start = 1'b0, tick = 1'b0, done_in = 1'b0;
    bit   sel = 1'b0;

    logic a_rc, a_oe, a_sk_en, a_sk, a_sd_en, a_sd, a_cs_en, a_cs, a_req, a_done;
    logic b_rc, b_oe, b_sk_en, b_sk, b_sd_en, b_sd, b_cs_en, b_cs, b_req, b_done;
    logic [7:0]  a_addr, b_addr;
    logic [15:0] a_data, b_data;
    logic start_a, start_b, done_a, done_b;

    assign start_a = start && !sel;
    assign start_b = start && sel;
    assign done_a  = done_in && !sel;
    assign done_b  = done_in && sel;

    sw_rst_init_seq #(.RST_EN(1'b1), .T_HI_MS(THI), .T_LO_MS(TLO), .T_REC_MS(TREC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_a), .ms_tick_i(tick),
        .rc_o(a_rc), .rc_oe_o(a_oe), .sclk_ovr_en_o(a_sk_en), .sclk_ovr_o(a_sk),
        .sdat_ovr_en_o(a_sd_en), .sdat_ovr_o(a_sd), .csel_ovr_en_o(a_cs_en), .csel_ovr_o(a_cs),
        .wr_req_o(a_req), .wr_addr_o(a_addr), .wr_data_o(a_data), .wr_done_i(done_a), .done_o(a_done));

    sw_rst_init_seq #(.RST_EN(1'b0), .T_HI_MS(THI), .T_LO_MS(TLO), .T_REC_MS(TREC)) dut_nr_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_b), .ms_tick_i(tick),
        .rc_o(b_rc), .rc_oe_o(b_oe), .sclk_ovr_en_o(b_sk_en), .sclk_ovr_o(b_sk),
        .sdat_ovr_en_o(b_sd_en), .sdat_ovr_o(b_sd), .csel_ovr_en_o(b_cs_en), .csel_ovr_o(b_cs),
        .wr_req_o(b_req), .wr_addr_o(b_addr), .wr_data_o(b_data), .wr_done_i(done_b), .done_o(b_done));

    logic m_rc, m_oe, m_sk_en, m_sk, m_sd_en, m_sd, m_cs_en, m_cs, m_req, m_done;
    logic [7:0]  m_addr;
    logic [15:0] m_data;

    always_comb begin
        if (sel) begin
            {m_rc, m_oe, m_sk_en, m_sk, m_sd_en, m_sd, m_cs_en, m_cs, m_req, m_done} =
                {b_rc, b_oe, b_sk_en, b_sk, b_sd_en, b_sd, b_cs_en, b_cs, b_req, b_done};
            m_addr = b_addr; m_data = b_data;
        end else begin
            {m_rc, m_oe, m_sk_en, m_sk, m_sd_en, m_sd, m_cs_en, m_cs, m_req, m_done} =
                {a_rc, a_oe, a_sk_en, a_sk, a_sd_en, a_sd, a_cs_en, a_cs, a_req, a_done};
            m_addr = a_addr; m_data = a_data;
        end
    end

    int nchk = 0, nfail = 0;

    // monitor state
    bit run_on = 0, go = 0, inj = 0, injected = 0;
    int per = 1, lat = 0, div = 0, wcnt = 0, cyc = 0, first_req = -1;
    int ph_hi, ph_lo, ph_rec, nwr;
    bit seen_low, seen_rise, last_lo_ok, preset_ok, early_req, hold_bad, oe_seen;
    logic [7:0]  wa [2];
    logic [15:0] wd [2];
    logic [7:0]  pend_addr;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Tick source, master model and observer, all at the falling edge
    always @(negedge clk) begin
        bit t;
        if (!run_on) begin
            tick = 0; done_in = 0; start = 0;
        end else begin
            t   = (div == per - 1);
            div = t ? 0 : div + 1;
            start = go || (inj && !injected && seen_low && ph_lo == 50);
            if (start && !go) injected = 1;
            go = 0;
            cyc++;
            if (m_oe) oe_seen = 1;
            if (m_oe && m_rc && !seen_low && !m_req && !m_done) ph_hi += int'(t);
            if (m_oe && !m_rc) begin
                seen_low   = 1;
                ph_lo     += int'(t);
                last_lo_ok = m_sk_en && m_sk && m_sd_en && !m_sd && m_cs_en && !m_cs;
            end
            if (seen_low && m_rc && m_sk_en) begin
                if (!seen_rise) preset_ok = last_lo_ok;
                seen_rise = 1;
                ph_rec   += int'(t);
            end
            if (m_req) begin
                if (first_req < 0) first_req = cyc;
                if (m_sk_en || m_cs_en || (!sel && !seen_rise)) early_req = 1;
                if (wcnt > 0 && m_addr != pend_addr) hold_bad = 1;
                pend_addr = m_addr;
                if (wcnt == lat) begin
                    done_in = 1;
                    if (nwr < 2) begin wa[nwr] = m_addr; wd[nwr] = m_data; end
                    nwr++;
                    wcnt = 0;
                end else begin
                    done_in = 0;
                    wcnt++;
                end
            end else begin
                done_in = 0;
                wcnt = 0;
            end
            tick = t;
        end
    end

    task automatic run_seq(input bit s, input int p, input int l, input bit inject);
        int guard;
        sel = s; per = p; lat = l; inj = inject; injected = 0;
        div = 0; wcnt = 0; cyc = 0; first_req = -1;
        ph_hi = 0; ph_lo = 0; ph_rec = 0; nwr = 0;
        seen_low = 0; seen_rise = 0; last_lo_ok = 0; preset_ok = 0;
        early_req = 0; hold_bad = 0; oe_seen = 0; pend_addr = '0;
        @(negedge clk); #1;
        run_on = 1; go = 1;
        guard = 0;
        do begin @(negedge clk); #1; guard++; end while (m_done && guard < 10);
        guard = 0;
        while (!m_done && guard < 3000) begin @(negedge clk); #1; guard++; end
        chk(guard < 3000, "R8 watchdog", guard, 0);
        repeat (3) begin @(negedge clk); #1; end
        run_on = 0;
        // R8 done held with no further start
        chk(m_done == 1'b1, "R8", m_done, 1);
        // R5 order, addresses and values
        chk(nwr == 2, "R7 handshake count", nwr, 2);
        chk(wa[0] == 8'h09 && wd[0] == 16'hBC1F, "R5 first write", {wa[0], wd[0]}, {8'h09, 16'hBC1F});
        chk(wa[1] == 8'h11 && wd[1] == 16'hFF30, "R5 second write", {wa[1], wd[1]}, {8'h11, 16'hFF30});
        chk(!early_req, "R5 request timing", early_req, 0);
        chk(!hold_bad, "R7 hold", hold_bad, 0);
        if (!s) begin
            chk(ph_hi == THI + 1, "R1", ph_hi, THI + 1);
            chk(ph_lo == TLO + 1, "R2", ph_lo, TLO + 1);
            chk(preset_ok, "R3", preset_ok, 1);
            chk(ph_rec == TREC + 1, "R4 recovery", ph_rec, TREC + 1);
            chk(m_oe && m_rc && !m_sk_en && !m_sd_en && !m_cs_en, "R4 release",
                {m_oe, m_rc, m_sk_en, m_sd_en, m_cs_en}, 5'b11000);
            if (inject) chk(injected && nwr == 2 && ph_lo == TLO + 1 && ph_hi == THI + 1,
                            "R9", ph_lo, TLO + 1);
        end else begin
            chk(!oe_seen && ph_hi == 0 && ph_lo == 0, "R6 no reset drive", oe_seen, 0);
            chk(first_req == 2, "R6 first request", first_req, 2);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R10 reset state of both variants
        chk(!a_oe && !a_sk_en && !a_sd_en && !a_cs_en && !a_req && !a_done, "R10 main",
            {a_oe, a_sk_en, a_sd_en, a_cs_en, a_req, a_done}, 0);
        chk(!b_oe && !b_sk_en && !b_sd_en && !b_cs_en && !b_req && !b_done, "R10 bypass",
            {b_oe, b_sk_en, b_sd_en, b_cs_en, b_req, b_done}, 0);
        for (int p = 1; p <= 3; p++)
            for (int l = 0; l <= 2; l++)
                run_seq(1'b0, p, l, l == 1);
        for (int l = 0; l <= 3; l++)
            run_seq(1'b1, 1, l, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // Global watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule